// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is a two-address configuration port for chipset control registers. A write to the even address loads an index register. The odd address is the data window onto the register that the index selects. The other chipset logic reads the stored registers directly from a flat export bus. Software drives the port through address bit 0, a read strobe, a write strobe and an 8-bit data bus. Reads are combinational, so read data is valid in the same cycle as the read strobe.

The port leaves reset locked. While it is locked, reads return all ones and data writes store nothing. Each locked data write is remembered by a key detector. Two consecutive locked data writes of 0x14 and then 0x09 open the port. Once the port is open, registers can be written and read back. Any data write made while the index is 0xFF locks the port again.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the port is locked, the index is 0x00, and every read returns 0xFF.
- R2: A write with address bit 0 low loads the index from the write data, whether the port is locked or open.
- R3: While locked, a read returns 0xFF at either address.
- R4: While locked, a write with address bit 0 high leaves every stored register unchanged.
- R5: While locked, the port opens on a data write of 0x09 when the previous locked data write was 0x14. Index writes made between the two do not break the pair. Any other data write in between does break it. The remembered value clears to 0x00 at reset and changes only on locked data writes.
- R6: While open, a data write with the index below 0x10 stores the data in that register. The change is visible on the export bus and on odd-address reads from the next cycle.
- R7: While open, a data write with the index in 0x10..0x43 is discarded. An odd-address read with the index in 0x10..0x43 returns 0x00. An odd-address read with the index at 0x44 or above returns 0xFF.
- R8: While open, a data write with the index equal to 0xFF locks the port, whatever the value written, and stores nothing.
- R9: At reset, register 0x0F holds 0x08 and every other register holds 0x00. The export bus carries register i in bits [8*i+7 : 8*i].
- R10: While the read strobe is low, the read data output is 0xFF.
- R11: While open, a read with address bit 0 low returns the current index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr0_i | input | 1 | Address bit 0: 0 selects the index, 1 selects data |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe, sampled at the clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| regs_o | output | 128 | Flat export of the 16 stored registers |

## Verification
Several properties are checked on every cycle. Locked reads always return all ones, and the strobe-low idle value is also all ones. The export bus cannot change while the port is locked, and it cannot change on a write to an index with no storage. The key pair always opens the port, a write at index 0xFF always locks it, and an index write always lands in the index. Other behaviours need ordered stimulus that only the bench scenarios provide. These include a broken key pair staying locked, an index write between the two key bytes not breaking the pair, and the read values across the three index ranges after a mix of random writes.

// File: rtl/keyed_cfg_pkg.sv
package keyed_cfg_pkg;
   typedef enum logic {
      CFG_LOCKED = 1'b0,
      CFG_OPEN   = 1'b1
   } cfg_lock_e;

   localparam int unsigned CFG_DW_DEF       = 8;
   localparam int unsigned CFG_NREG_DEF     = 16;
   localparam int unsigned CFG_WINDOW_DEF   = 'h44;
   localparam int unsigned CFG_KEY_FIRST    = 'h14;
   localparam int unsigned CFG_KEY_SECOND   = 'h09;
   localparam int unsigned CFG_RELOCK_IDX   = 'hFF;
   localparam int unsigned CFG_RST_IDX_DEF  = 'h0F;
   localparam int unsigned CFG_RST_VAL_DEF  = 'h08;
endpackage

// File: rtl/keyed_cfg_index.sv
module keyed_cfg_index #(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          idx_wr_i,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] idx_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        idx_o <= '0;
      else if (idx_wr_i) idx_o <= wdata_i;
   end
endmodule

// File: rtl/keyed_cfg_lock.sv
module keyed_cfg_lock
   import keyed_cfg_pkg::*;
#(
   parameter int unsigned DW         = 8,
   parameter int unsigned KEY_FIRST  = CFG_KEY_FIRST,
   parameter int unsigned KEY_SECOND = CFG_KEY_SECOND,
   parameter int unsigned RELOCK_IDX = CFG_RELOCK_IDX
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          data_wr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic [DW-1:0] idx_i,
   output logic          open_o,
   output logic [DW-1:0] prev_o
);
   localparam logic [DW-1:0] K1 = DW'(KEY_FIRST);
   localparam logic [DW-1:0] K2 = DW'(KEY_SECOND);
   localparam logic [DW-1:0] RL = DW'(RELOCK_IDX);

   cfg_lock_e state_q, state_d;
   logic [DW-1:0] prev_q, prev_d;

   always_comb begin
      state_d = state_q;
      prev_d  = prev_q;
      if (data_wr_i) begin
         if (state_q == CFG_LOCKED) begin
            prev_d = wdata_i;
            if (prev_q == K1 && wdata_i == K2) state_d = CFG_OPEN;
         end else if (idx_i == RL) begin
            state_d = CFG_LOCKED;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CFG_LOCKED;
         prev_q  <= '0;
      end else begin
         state_q <= state_d;
         prev_q  <= prev_d;
      end
   end

   assign open_o = (state_q == CFG_OPEN);
   assign prev_o = prev_q;
endmodule

// File: rtl/keyed_cfg_regfile.sv
module keyed_cfg_regfile #(
   parameter int unsigned DW      = 8,
   parameter int unsigned NREG    = 16,
   parameter int unsigned RST_IDX = 15,
   parameter int unsigned RST_VAL = 8,
   localparam int unsigned AW     = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we_i,
   input  logic [AW-1:0]      waddr_i,
   input  logic [DW-1:0]      wdata_i,
   output logic [NREG*DW-1:0] regs_o
);
   for (genvar g = 0; g < NREG; g++) begin : g_reg
      localparam logic [DW-1:0] INIT = (g == RST_IDX) ? DW'(RST_VAL) : '0;
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 q <= INIT;
         else if (we_i && waddr_i == AW'(g))         q <= wdata_i;
      end
      assign regs_o[g*DW +: DW] = q;
   end
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
   import keyed_cfg_pkg::*;
#(
   parameter int unsigned DW         = CFG_DW_DEF,
   parameter int unsigned NREG       = CFG_NREG_DEF,
   parameter int unsigned WINDOW     = CFG_WINDOW_DEF,
   parameter int unsigned KEY_FIRST  = CFG_KEY_FIRST,
   parameter int unsigned KEY_SECOND = CFG_KEY_SECOND,
   parameter int unsigned RELOCK_IDX = CFG_RELOCK_IDX,
   parameter int unsigned RST_IDX    = CFG_RST_IDX_DEF,
   parameter int unsigned RST_VAL    = CFG_RST_VAL_DEF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               addr0_i,
   input  logic               rd_en_i,
   input  logic               wr_en_i,
   input  logic [DW-1:0]      wdata_i,
   output logic [DW-1:0]      rdata_o,
   output logic [NREG*DW-1:0] regs_o
);
   localparam int unsigned AW = (NREG > 1) ? $clog2(NREG) : 1;
   localparam logic [DW:0] NREG_W   = (DW+1)'(NREG);
   localparam logic [DW:0] WINDOW_W = (DW+1)'(WINDOW);

   if (NREG > WINDOW) begin : g_bad_nreg
      $error("keyed_cfg_port: NREG must not exceed WINDOW");
   end
   if (WINDOW > (1 << DW)) begin : g_bad_window
      $error("keyed_cfg_port: WINDOW exceeds index range");
   end
   if (RST_IDX >= NREG) begin : g_bad_rst
      $error("keyed_cfg_port: RST_IDX outside storage");
   end
   if (RELOCK_IDX < NREG) begin : g_bad_relock
      $error("keyed_cfg_port: RELOCK_IDX must not address storage");
   end

   logic          idx_wr, data_wr, open_w, store_hit, window_hit;
   logic [DW-1:0] idx_q, prev_w;

   assign idx_wr  = wr_en_i & ~addr0_i;
   assign data_wr = wr_en_i &  addr0_i;

   keyed_cfg_index #(.DW(DW)) u_index (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx_wr_i(idx_wr),
      .wdata_i (wdata_i),
      .idx_o   (idx_q)
   );

   keyed_cfg_lock #(
      .DW(DW), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND),
      .RELOCK_IDX(RELOCK_IDX)
   ) u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .data_wr_i(data_wr),
      .wdata_i  (wdata_i),
      .idx_i    (idx_q),
      .open_o   (open_w),
      .prev_o   (prev_w)
   );

   assign store_hit  = ({1'b0, idx_q} < NREG_W);
   assign window_hit = ({1'b0, idx_q} < WINDOW_W);

   keyed_cfg_regfile #(
      .DW(DW), .NREG(NREG), .RST_IDX(RST_IDX), .RST_VAL(RST_VAL)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_i   (data_wr & open_w & store_hit),
      .waddr_i(idx_q[AW-1:0]),
      .wdata_i(wdata_i),
      .regs_o (regs_o)
   );

   always_comb begin
      rdata_o = '1;
      if (rd_en_i && open_w) begin
         if (!addr0_i)        rdata_o = idx_q;
         else if (store_hit)  rdata_o = regs_o[idx_q[AW-1:0]*DW +: DW];
         else if (window_hit) rdata_o = '0;
      end
   end
endmodule

// File: rtl/keyed_cfg_chk.sv
module keyed_cfg_chk #(
   parameter int unsigned DW         = 8,
   parameter int unsigned NREG       = 16,
   parameter int unsigned KEY_FIRST  = 'h14,
   parameter int unsigned KEY_SECOND = 'h09,
   parameter int unsigned RELOCK_IDX = 'hFF
) (
   input logic               clk,
   input logic               rst_n,
   input logic               addr0_i,
   input logic               rd_en_i,
   input logic               wr_en_i,
   input logic [DW-1:0]      wdata_i,
   input logic [DW-1:0]      rdata_o,
   input logic [NREG*DW-1:0] regs_o,
   input logic               open_w,
   input logic [DW-1:0]      prev_w,
   input logic [DW-1:0]      idx_q
);
   // R3
   locked_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!open_w && rd_en_i) |-> rdata_o == '1);
   // R10
   idle_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_i |-> rdata_o == '1);
   // R4
   locked_regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !open_w |=> $stable(regs_o));
   // R5
   key_pair_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!open_w && wr_en_i && addr0_i && prev_w == DW'(KEY_FIRST)
       && wdata_i == DW'(KEY_SECOND)) |=> open_w);
   // R8
   relock_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (open_w && wr_en_i && addr0_i && idx_q == DW'(RELOCK_IDX)) |=> !open_w);
   // R2
   index_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !addr0_i) |=> idx_q == $past(wdata_i));
   // R7
   unbacked_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && addr0_i && {1'b0, idx_q} >= (DW+1)'(NREG)) |=> $stable(regs_o));
endmodule

bind keyed_cfg_port keyed_cfg_chk #(
   .DW(DW), .NREG(NREG), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND),
   .RELOCK_IDX(RELOCK_IDX)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .addr0_i(addr0_i),
   .rd_en_i(rd_en_i),
   .wr_en_i(wr_en_i),
   .wdata_i(wdata_i),
   .rdata_o(rdata_o),
   .regs_o (regs_o),
   .open_w (open_w),
   .prev_w (prev_w),
   .idx_q  (idx_q)
);

// File: tb/keyed_cfg_port_bench.sv
`timescale 1ns/1ps
module keyed_cfg_port_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         addr0 = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
   logic [7:0]   wdata = '0;
   logic [7:0]   rdata;
   logic [127:0] regs;

   int n_tests = 0, n_fail = 0;

   bit         m_locked;
   logic [7:0] m_prev, m_idx;
   logic [7:0] m_regs [16];

   always #5 clk = ~clk;

   keyed_cfg_port u_keyed_cfg_port (
      .clk(clk), .rst_n(rst_n), .addr0_i(addr0), .rd_en_i(rd_en),
      .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata), .regs_o(regs)
   );

   function automatic logic [7:0] exp_read(bit a0);
      if (m_locked) return 8'hFF;
      if (!a0) return m_idx;
      if (m_idx < 8'h10) return m_regs[m_idx[3:0]];
      if (m_idx < 8'h44) return 8'h00;
      return 8'hFF;
   endfunction

   function automatic logic [127:0] exp_regs();
      logic [127:0] v;
      for (int i = 0; i < 16; i++) v[i*8 +: 8] = m_regs[i];
      return v;
   endfunction

   task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_locked = 1'b1; m_prev = 8'h00; m_idx = 8'h00;
      for (int i = 0; i < 16; i++) m_regs[i] = 8'h00;
      m_regs[15] = 8'h08;
   endtask

   task automatic do_wr(bit a0, logic [7:0] d);
      @(negedge clk);
      addr0 = a0; wr_en = 1'b1; wdata = d;
      @(posedge clk);
      if (!a0) m_idx = d;
      else if (m_locked) begin
         if (m_prev == 8'h14 && d == 8'h09) m_locked = 1'b0;
         m_prev = d;
      end else if (m_idx == 8'hFF) m_locked = 1'b1;
      else if (m_idx < 8'h10) m_regs[m_idx[3:0]] = d;
      #1 wr_en = 1'b0;
   endtask

   task automatic chk_rd(bit a0, string tag);
      @(negedge clk);
      addr0 = a0; rd_en = 1'b1;
      #1 check(tag, {120'd0, rdata}, {120'd0, exp_read(a0)});
      rd_en = 1'b0;
   endtask

   task automatic chk_regs(string tag);
      @(negedge clk);
      check(tag, regs, exp_regs());
   endtask

   task automatic unlock();
      do_wr(1'b1, 8'h14); do_wr(1'b1, 8'h09);
   endtask

   initial begin
      #1_500_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 / R9: reset state
      chk_rd(1'b0, "R1 index read after reset");
      chk_rd(1'b1, "R1 data read after reset");
      chk_regs("R9 reset values");
      // R10: strobe low
      #1 check("R10 idle read", {120'd0, rdata}, {120'd0, 8'hFF});

      // R4 / R3: locked writes store nothing
      do_wr(1'b0, 8'h03); do_wr(1'b1, 8'hAA);
      chk_regs("R4 locked write ignored");
      chk_rd(1'b1, "R3 locked data read");
      // R5: broken pair
      do_wr(1'b1, 8'h14); do_wr(1'b1, 8'h22); do_wr(1'b1, 8'h09);
      chk_rd(1'b0, "R5 broken pair stays locked");
      // R5 / R2: index write between key bytes
      do_wr(1'b1, 8'h14); do_wr(1'b0, 8'h05); do_wr(1'b1, 8'h09);
      chk_rd(1'b0, "R2 R11 index after unlock");
      // R6
      do_wr(1'b1, 8'h5A);
      chk_rd(1'b1, "R6 stored read back");
      chk_regs("R6 export bus");
      // R7
      do_wr(1'b0, 8'h20); do_wr(1'b1, 8'h77);
      chk_regs("R7 unbacked write dropped");
      chk_rd(1'b1, "R7 unbacked read zero");
      do_wr(1'b0, 8'h43); chk_rd(1'b1, "R7 last window index");
      do_wr(1'b0, 8'h44); chk_rd(1'b1, "R7 outside window");
      do_wr(1'b0, 8'h0F); chk_rd(1'b1, "R9 reg 0F");
      // R8
      do_wr(1'b0, 8'hFF); do_wr(1'b1, 8'h14);
      chk_regs("R8 relock stores nothing");
      chk_rd(1'b0, "R8 relocked");
      // R5: previous value survives relock (0x14 not remembered while open)
      do_wr(1'b1, 8'h09);
      chk_rd(1'b0, "R5 stale key stays locked");

      // random phase
      for (int k = 0; k < 3000; k++) begin
         int unsigned op = $urandom_range(0, 9);
         logic [7:0] v;
         case ($urandom_range(0, 5))
            0: v = 8'h14;
            1: v = 8'h09;
            2: v = 8'hFF;
            3: v = 8'(8'h10 + $urandom_range(0, 'h40));
            default: v = 8'($urandom_range(0, 15));
         endcase
         if (op < 3)      do_wr(1'b0, v);
         else if (op < 7) do_wr(1'b1, ($urandom_range(0, 2) == 0) ? 8'($urandom) : v);
         else if (op < 8) chk_rd(1'b0, "R11 random index read");
         else             chk_rd(1'b1, "R6 random data read");
         if (k % 16 == 0) chk_regs("R6 random export");
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule